// File: doc/BRIEF.md
# Motor Stall and Command-Clock Supervisor

This block guards the low-side gate drive of a three-phase motor driver. It watches the speed-lock flag, pulses that mark edges of the speed command clock, the start and brake requests, and two fault flags raised by analog sensing elsewhere: over-temperature and undervoltage. All timing is counted in ticks of a slow timebase, supplied as a one-cycle strobe.

The block is armed only in the drive state, which means start requested, brake not requested, and the power-on window over. While armed, it counts timebase ticks for as long as the lock flag stays low. Any lock indication restarts that count. When the count reaches the stall time, a stall latch is set and the low-side drive is held off.

The latch survives stop and brake requests. It is cleared by a reset, or by a qualified re-arm: a stop or brake request held for at least a release time, followed by a return to the drive request. A separate watchdog treats the command clock as lost after a tick gap longer than one thirty-fourth of the stall time. Clock loss disables the low side only while the loss lasts. While clock loss, over-temperature or undervoltage is active, the stall count is frozen.

Top module: `stall_guard_supervisor`

## Requirements
- R1: After reset, `all_off` and `lowside_off` are high and `stall_latched` is low. `all_off` stays high until POR_TICKS timebase ticks have been counted, and goes low once the last of them has been counted.
- R2: While `uv_flt` is high, `all_off` and `lowside_off` are both high in the same cycle.
- R3: Over-temperature (`thermal_flt` high) drives `lowside_off` high, without `all_off`, in the drive state only. Outside the drive state it has no effect on either output.
- R4: In the drive state (`run_req`=1, `brake_req`=0, power-on window over), `stall_latched` is set after STALL_TICKS consecutive ticks with `locked`=0, and not after STALL_TICKS-1 ticks. While the latch is set in the drive state, `lowside_off` is high.
- R5: A cycle with `locked`=1 restarts the stall count from zero, so a further full STALL_TICKS unlocked ticks are needed.
- R6: While clock loss, `thermal_flt` or `uv_flt` is active, ticks are not counted toward a stall. The count is held and resumes afterwards.
- R7: In the drive state, the command clock is lost when more than LOSS ticks pass without a `cmd_edge` pulse, where LOSS = STALL_TICKS/34 (integer division, at least 1). Loss drives `lowside_off` high. A gap of exactly LOSS ticks does not.
- R8: Clock loss clears on the first clock edge that carries a `cmd_edge` pulse.
- R9: A stop request (`run_req`=0) held for at least RELEASE_TICKS ticks, followed by `run_req`=1 with `brake_req`=0, clears `stall_latched` on that edge. A shorter stop leaves the latch set.
- R10: A brake request (`brake_req`=1) held for at least RELEASE_TICKS ticks, followed by its release, clears the latch in the same way. A shorter brake leaves it set.
- R11: Outside the drive state, neither the stall count nor the clock-gap count advances: both restart from zero on re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick | input | 1 | One-cycle timebase strobe |
| run_req | input | 1 | 1 = start requested, 0 = stop |
| brake_req | input | 1 | 1 = short brake requested |
| locked | input | 1 | 1 = motor speed within lock range |
| cmd_edge | input | 1 | 1 = a command clock edge was seen this cycle |
| thermal_flt | input | 1 | Over-temperature flag |
| uv_flt | input | 1 | Undervoltage flag |
| lowside_off | output | 1 | 1 = low-side gate drive disabled |
| all_off | output | 1 | 1 = every gate output forced off |
| stall_latched | output | 1 | Stall latch status |

## Verification
The fault outputs for `uv_flt` and `thermal_flt` are combinational, so the bench samples them one time unit after it drives the input.

Every counter-based result appears one clock edge after the tick that completes the count: the power-on release, clock loss, and the count reaching STALL_TICKS. The stall latch needs one further edge after that. The bench therefore issues each tick as a two-cycle step (strobe, then idle) and samples on the falling edge after the idle cycle.

A qualified release clears the latch on the first edge with the drive request restored, and clock loss clears on the first edge carrying an edge pulse. Both are checked on the next falling edge.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

  // Clock-loss gap limit derived from the stall time (at least one tick).
  function automatic int unsigned loss_ticks(input int unsigned stall);
    int unsigned q;
    q = stall / 34;
    return (q < 1) ? 1 : q;
  endfunction

  // Counter width able to hold 0..maxv.
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/sgs_tick_counter.sv
module sgs_tick_counter #(
  parameter int unsigned MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic full
);
  import stall_guard_pkg::*;

  localparam int unsigned W = cnt_width(MAX);
  localparam logic [W-1:0] LIMIT = W'(MAX);

  logic [W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr) begin
      count_q <= '0;
    end else if (step && (count_q != LIMIT)) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign full = (count_q == LIMIT);
endmodule

// File: rtl/sgs_clock_watch.sv
module sgs_clock_watch #(
  parameter int unsigned LOSS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic cmd_edge,
  output logic lost
);
  // Gap counter saturates at LOSS+1; reaching it means "longer than LOSS".
  sgs_tick_counter #(.MAX(LOSS + 1)) u_gap (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cmd_edge | ~armed),
    .step (tick),
    .full (lost)
  );
endmodule

// File: rtl/sgs_stall_ctrl.sv
module sgs_stall_ctrl #(
  parameter int unsigned STALL   = 136,
  parameter int unsigned RELEASE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic drive_req,
  input  logic locked,
  input  logic inhibit,
  output logic set_evt,
  output logic release_evt,
  output logic latched
);
  logic stall_full;
  logic idle_full;
  logic latch_q;

  // Unlocked-time counter: restarts on lock or disarm, frozen while inhibited.
  sgs_tick_counter #(.MAX(STALL)) u_stall_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (locked | ~armed),
    .step (tick & ~inhibit),
    .full (stall_full)
  );

  // Stop/brake duration qualifier: runs while the drive request is absent.
  sgs_tick_counter #(.MAX(RELEASE)) u_idle_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (drive_req),
    .step (tick),
    .full (idle_full)
  );

  assign set_evt     = stall_full & armed & ~locked;
  assign release_evt = idle_full & drive_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (release_evt) begin
      latch_q <= 1'b0;
    end else if (set_evt) begin
      latch_q <= 1'b1;
    end
  end

  assign latched = latch_q;
endmodule

// File: rtl/stall_guard_supervisor.sv
module stall_guard_supervisor #(
  parameter int unsigned STALL_TICKS   = 3400,
  parameter int unsigned RELEASE_TICKS = 16,
  parameter int unsigned POR_TICKS     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_req,
  input  logic brake_req,
  input  logic locked,
  input  logic cmd_edge,
  input  logic thermal_flt,
  input  logic uv_flt,
  output logic lowside_off,
  output logic all_off,
  output logic stall_latched
);
  import stall_guard_pkg::*;

  localparam int unsigned LOSS_TICKS = loss_ticks(STALL_TICKS);

  // Named internal events, visible to the bound checker.
  logic por_done_w;
  logic por_active_w;
  logic drive_req_w;
  logic armed_w;
  logic clk_lost_w;
  logic inhibit_w;
  logic stall_set_w;
  logic release_w;

  sgs_tick_counter #(.MAX(POR_TICKS)) u_por (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (1'b0),
    .step (tick),
    .full (por_done_w)
  );

  assign por_active_w = ~por_done_w;
  assign drive_req_w  = run_req & ~brake_req;
  assign armed_w      = drive_req_w & por_done_w;

  sgs_clock_watch #(.LOSS(LOSS_TICKS)) u_clk_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .armed   (armed_w),
    .cmd_edge(cmd_edge),
    .lost    (clk_lost_w)
  );

  assign inhibit_w = clk_lost_w | thermal_flt | uv_flt;

  sgs_stall_ctrl #(.STALL(STALL_TICKS), .RELEASE(RELEASE_TICKS)) u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .armed      (armed_w),
    .drive_req  (drive_req_w),
    .locked     (locked),
    .inhibit    (inhibit_w),
    .set_evt    (stall_set_w),
    .release_evt(release_w),
    .latched    (stall_latched)
  );

  assign all_off     = por_active_w | uv_flt;
  assign lowside_off = all_off |
                       (armed_w & (stall_latched | clk_lost_w | thermal_flt));
endmodule

// File: rtl/stall_guard_supervisor_chk.sv
module stall_guard_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic run_req,
  input logic brake_req,
  input logic locked,
  input logic cmd_edge,
  input logic thermal_flt,
  input logic uv_flt,
  input logic lowside_off,
  input logic all_off,
  input logic stall_latched,
  input logic por_active_w,
  input logic armed_w,
  input logic clk_lost_w
);
  assert_por_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por_active_w |-> (all_off && lowside_off));

  assert_uv_all_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flt |-> (all_off && lowside_off));

  assert_thermal_lowside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_w && thermal_flt) |-> lowside_off);

  assert_stall_set_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_latched) |-> $past(armed_w && !locked));

  assert_latch_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_w && stall_latched) |-> lowside_off);

  assert_loss_lowside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_w && clk_lost_w) |-> lowside_off);

  assert_loss_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_lost_w) |-> $past(cmd_edge || !armed_w));

  assert_release_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_latched) |-> $past(run_req && !brake_req));
endmodule

bind stall_guard_supervisor stall_guard_supervisor_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_req      (run_req),
  .brake_req    (brake_req),
  .locked       (locked),
  .cmd_edge     (cmd_edge),
  .thermal_flt  (thermal_flt),
  .uv_flt       (uv_flt),
  .lowside_off  (lowside_off),
  .all_off      (all_off),
  .stall_latched(stall_latched),
  .por_active_w (por_active_w),
  .armed_w      (armed_w),
  .clk_lost_w   (clk_lost_w)
);

// File: tb/stall_guard_supervisor_bench.sv
module stall_guard_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STALL      = 136;
  localparam int RELEASE    = 3;
  localparam int POR        = 5;
  localparam int LOSS       = (STALL / 34 < 1) ? 1 : STALL / 34;

  logic clk = 1'b0;
  logic rst_n, tick, run_req, brake_req, locked, cmd_edge, thermal_flt, uv_flt;
  logic lowside_off, all_off, stall_latched;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stall_guard_supervisor #(
    .STALL_TICKS  (STALL),
    .RELEASE_TICKS(RELEASE),
    .POR_TICKS    (POR)
  ) u_stall_guard_supervisor (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .run_req      (run_req),
    .brake_req    (brake_req),
    .locked       (locked),
    .cmd_edge     (cmd_edge),
    .thermal_flt  (thermal_flt),
    .uv_flt       (uv_flt),
    .lowside_off  (lowside_off),
    .all_off      (all_off),
    .stall_latched(stall_latched)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Each tick: strobe cycle then idle cycle; returns on a falling edge.
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic lock_pulse();
    locked = 1'b1;
    @(negedge clk);
    locked = 1'b0;
  endtask

  // Hold stop (mode 0) or brake (mode 1) for s ticks, then restore drive.
  task automatic idle_for(input int s, input int mode);
    if (mode == 0) run_req = 1'b0; else brake_req = 1'b1;
    tk(s);
    run_req = 1'b1;
    brake_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; run_req = 1'b0; brake_req = 1'b0;
    locked = 1'b0; cmd_edge = 1'b1; thermal_flt = 1'b0; uv_flt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: power-on window
    check(all_off, 1'b1, "R1 all_off at reset");
    check(lowside_off, 1'b1, "R1 lowside_off at reset");
    check(stall_latched, 1'b0, "R1 stall_latched at reset");
    tk(POR - 1);
    check(all_off, 1'b1, "R1 all_off one tick early");
    tk(1);
    check(all_off, 1'b0, "R1 all_off after window");
    check(lowside_off, 1'b0, "R1 lowside_off stopped");

    // R3: thermal outside and inside drive state
    thermal_flt = 1'b1; #1;
    check(lowside_off, 1'b0, "R3 thermal ignored when stopped");
    check(all_off, 1'b0, "R3 thermal no all_off");
    run_req = 1'b1; #1;
    check(lowside_off, 1'b1, "R3 thermal lowside in drive");
    check(all_off, 1'b0, "R3 thermal no all_off in drive");
    thermal_flt = 1'b0; #1;
    check(lowside_off, 1'b0, "R3 thermal removed");

    // R2: undervoltage
    uv_flt = 1'b1; #1;
    check(all_off, 1'b1, "R2 uv all_off");
    check(lowside_off, 1'b1, "R2 uv lowside_off");
    uv_flt = 1'b0;
    @(negedge clk);

    // R4/R5/R9/R10: sweep lock-pulse position and release length, both modes
    for (int mode = 0; mode < 2; mode++) begin
      for (int s = 1; s <= RELEASE + 1; s++) begin
        lock_pulse();
        tk(s * 30);
        lock_pulse();
        tk(STALL - 1);
        check(stall_latched, 1'b0, "R5 restart, one tick short");
        tk(1);
        check(stall_latched, 1'b1, "R4 stall latched");
        check(lowside_off, 1'b1, "R4 lowside_off from latch");
        idle_for(s, mode);
        check(stall_latched, (s >= RELEASE) ? 1'b0 : 1'b1,
              (mode == 0) ? "R9 stop release" : "R10 brake release");
        if (stall_latched) idle_for(RELEASE, mode);
        check(stall_latched, 1'b0, "R9 full release clears");
      end
    end

    // R6: thermal freezes the count without clearing it
    lock_pulse();
    tk(100);
    thermal_flt = 1'b1;
    tk(50);
    thermal_flt = 1'b0;
    tk(STALL - 101);
    check(stall_latched, 1'b0, "R6 held count one short");
    tk(1);
    check(stall_latched, 1'b1, "R6 held count completes");
    idle_for(RELEASE, 1);
    check(stall_latched, 1'b0, "R10 brake clear after R6");

    // R7/R8: gap sweep, lock held so no stall counting
    locked = 1'b1;
    for (int g = 1; g <= LOSS + 2; g++) begin
      cmd_edge = 1'b1;
      @(negedge clk);
      cmd_edge = 1'b0;
      tk(g);
      check(lowside_off, (g > LOSS) ? 1'b1 : 1'b0, "R7 gap length vs loss");
      cmd_edge = 1'b1;
      @(negedge clk);
      check(lowside_off, 1'b0, "R8 loss cleared by edge");
    end

    // R11: no gap counting while stopped
    run_req = 1'b0;
    cmd_edge = 1'b0;
    tk(LOSS + 3);
    run_req = 1'b1; #1;
    check(lowside_off, 1'b0, "R11 gap restarted on re-arm");
    cmd_edge = 1'b1;
    @(negedge clk);

    // R11: no stall counting while braking
    locked = 1'b0;
    brake_req = 1'b1;
    tk(STALL + 5);
    check(stall_latched, 1'b0, "R11 no stall while braking");
    brake_req = 1'b0;
    tk(STALL - 1);
    check(stall_latched, 1'b0, "R11 count restarted on release");
    tk(1);
    check(stall_latched, 1'b1, "R4 stall after brake release");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule